// File: doc/BRIEF.md
# Pipeline Hazard and Flush Controller

This block is the hazard unit of a five-stage in-order integer pipeline. The stages are fetch, decode, execute, memory and write-back. It looks at the register indices and control flags of the instructions in flight. Each cycle it decides three things: which value each execute-stage operand takes, whether the front of the pipeline must wait one cycle, and whether the two youngest instructions must be discarded.

Read-after-write is the only dependence that can arise. Every such dependence is met by bypassing, except one: a load in execute whose result a decode-stage instruction reads. For that case the block holds the PC and the fetch/decode register and puts a bubble into decode/execute.

Branches resolve in execute, and fetch speculates not-taken until then. A taken branch, or any jump, squashes the two younger instructions. The jump itself continues to write-back so that its link register is written.

The block is purely combinational. Its outputs drive the pipeline register enables and the operand muxes within the same cycle. The register file is assumed to write before it reads, so decode never needs a bypass of its own.

Top module: `hazard_ctrl`

## Requirements
- R1: With no matching indices, no load in execute, and neither branch-taken nor jump, every hold, bubble and flush output is 0 and both selects are 2'b00 (register file).
- R2: When the memory stage writes a nonzero register equal to an execute source index, that operand's select is 2'b10. The value 2'b11 never appears.
- R3: When only the write-back stage writes a nonzero register equal to an execute source index, that operand's select is 2'b01.
- R4: When the memory and write-back stages both write the register an operand reads, the select is 2'b10, because the memory stage holds the younger result.
- R5: Register index 0 never produces a nonzero select and never produces a stall, even when a stage claims to write it.
- R6: A load in execute that writes a nonzero register read by either decode source raises hold_pc, hold_ifid and idex_bubble together.
- R7: A non-load in execute whose destination matches a decode source causes no hold and no bubble.
- R8: A taken branch in execute raises flush_ifid and flush_idex together.
- R9: A jump in execute raises both flushes whatever the branch-taken flag says.
- R10: When a flush and a load-use stall arise in the same cycle, the flush wins: both flushes are 1 and hold_pc, hold_ifid and idex_bubble are 0.
- R11: With both branch-taken and jump low, neither flush is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_AW | First source index of the decode-stage instruction |
| id_rs2 | input | REG_AW | Second source index of the decode-stage instruction |
| ex_rs1 | input | REG_AW | First source index of the execute-stage instruction |
| ex_rs2 | input | REG_AW | Second source index of the execute-stage instruction |
| ex_rd | input | REG_AW | Destination index in execute |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | REG_AW | Destination index in memory stage |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | REG_AW | Destination index in write-back |
| wb_wen | input | 1 | Write-back instruction writes a register |
| ex_br_taken | input | 1 | Branch in execute resolved as taken |
| ex_jump | input | 1 | Execute-stage instruction is an unconditional jump |
| hold_pc | output | 1 | Keep the PC unchanged this cycle |
| hold_ifid | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a no-op with all controls off into decode/execute |
| flush_ifid | output | 1 | Discard the instruction in fetch/decode |
| flush_idex | output | 1 | Discard the instruction entering decode/execute |
| fwd_a | output | 2 | First operand select: 00 register file, 01 write-back, 10 memory |
| fwd_b | output | 2 | Second operand select, same encoding |

## Verification
The assertions run on every cycle, and they cover the invariants. Select code 2'b11 never appears. Index 0 never forwards. The three stall outputs move together, and only for a load. The two flushes always move together. A jump always flushes, and no flush is raised without a branch-taken or jump. A flush never appears alongside a hold. Only the bench's scenarios can show that a select picks the correct stage, and that memory wins over write-back. They also show that the stall fires for the right source match, and that a wrong-path stall gives way to the flush.

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] ex_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  input  logic              ex_br_taken,
  input  logic              ex_jump,
  output logic              hold_pc,
  output logic              hold_ifid,
  output logic              idex_bubble,
  output logic              flush_ifid,
  output logic              flush_idex,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;

  logic mem_live, wb_live, ex_load_live;
  logic load_use, redirect;

  assign mem_live     = mem_wen && (mem_rd != ZERO_REG);
  assign wb_live      = wb_wen && (wb_rd != ZERO_REG);
  assign ex_load_live = ex_is_load && ex_wen && (ex_rd != ZERO_REG);

  function automatic logic [1:0] pick(input logic [REG_AW-1:0] src,
                                      input logic m_ok, input logic [REG_AW-1:0] m_rd,
                                      input logic w_ok, input logic [REG_AW-1:0] w_rd);
    if (m_ok && m_rd == src)      pick = SEL_MEM;
    else if (w_ok && w_rd == src) pick = SEL_WB;
    else                          pick = SEL_RF;
  endfunction

  assign fwd_a = pick(ex_rs1, mem_live, mem_rd, wb_live, wb_rd);
  assign fwd_b = pick(ex_rs2, mem_live, mem_rd, wb_live, wb_rd);

  assign load_use = ex_load_live && ((ex_rd == id_rs1) || (ex_rd == id_rs2));
  assign redirect = ex_br_taken || ex_jump;

  assign flush_ifid  = redirect;
  assign flush_idex  = redirect;
  assign hold_pc     = load_use && !redirect;
  assign hold_ifid   = load_use && !redirect;
  assign idex_bubble = load_use && !redirect;
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] ex_rs1,
  input logic [REG_AW-1:0] ex_rs2,
  input logic              ex_is_load,
  input logic              ex_br_taken,
  input logic              ex_jump,
  input logic              hold_pc,
  input logic              hold_ifid,
  input logic              idex_bubble,
  input logic              flush_ifid,
  input logic              flush_idex,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b
);
  always_comb begin
    a_r2_sel_legal: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
    a_r5_x0_a:      assert (ex_rs1 != '0 || fwd_a == 2'b00);
    a_r5_x0_b:      assert (ex_rs2 != '0 || fwd_b == 2'b00);
    a_r6_hold_pair: assert (hold_pc == hold_ifid && hold_pc == idex_bubble);
    a_r7_nonload:   assert (ex_is_load || (!hold_pc && !idex_bubble));
    a_r8_flush_pair: assert (flush_ifid == flush_idex);
    a_r9_jump:      assert (!ex_jump || flush_ifid);
    a_r10_flush_wins: assert (!flush_ifid || (!hold_pc && !hold_ifid && !idex_bubble));
    a_r11_quiet:    assert (ex_br_taken || ex_jump || !flush_idex);
  end
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
  .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_is_load(ex_is_load),
  .ex_br_taken(ex_br_taken), .ex_jump(ex_jump),
  .hold_pc(hold_pc), .hold_ifid(hold_ifid), .idex_bubble(idex_bubble),
  .flush_ifid(flush_ifid), .flush_idex(flush_idex),
  .fwd_a(fwd_a), .fwd_b(fwd_b)
);

// File: tb/hazard_ctrl_test.sv
module hazard_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int WATCHDOG = 2000;

  logic clk = 1'b0;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_wen, ex_is_load, mem_wen, wb_wen, ex_br_taken, ex_jump;
  logic hold_pc, hold_ifid, idex_bubble, flush_ifid, flush_idex;
  logic [1:0] fwd_a, fwd_b;
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_ctrl #(.REG_AW(AW)) uut (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
    .ex_br_taken(ex_br_taken), .ex_jump(ex_jump),
    .hold_pc(hold_pc), .hold_ifid(hold_ifid), .idex_bubble(idex_bubble),
    .flush_ifid(flush_ifid), .flush_idex(flush_idex),
    .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic clear();
    @(negedge clk);
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
    {ex_wen, ex_is_load, mem_wen, wb_wen, ex_br_taken, ex_jump} = '0;
  endtask

  // expected = {hold_pc, hold_ifid, idex_bubble, flush_ifid, flush_idex, fwd_a, fwd_b}
  task automatic check(input string req, input logic [8:0] exp);
    logic [8:0] act;
    #1;
    act = {hold_pc, hold_ifid, idex_bubble, flush_ifid, flush_idex, fwd_a, fwd_b};
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic t_idle();
    clear();
    check("R1 reset-like idle", 9'b00000_00_00);
    clear();
    id_rs1 = 3; id_rs2 = 4; ex_rs1 = 6; ex_rs2 = 7; ex_rd = 9; ex_wen = 1;
    mem_rd = 10; mem_wen = 1; wb_rd = 11; wb_wen = 1;
    check("R1 unrelated indices", 9'b00000_00_00);
  endtask

  task automatic t_fwd_mem();
    clear();
    ex_rs1 = 5; ex_rs2 = 8; mem_rd = 5; mem_wen = 1;
    check("R2 mem to a", 9'b00000_10_00);
    clear();
    ex_rs1 = 2; ex_rs2 = 12; mem_rd = 12; mem_wen = 1;
    check("R2 mem to b", 9'b00000_00_10);
    clear();
    ex_rs1 = 12; mem_rd = 12; mem_wen = 0;
    check("R2 mem without write enable", 9'b00000_00_00);
  endtask

  task automatic t_fwd_wb();
    clear();
    ex_rs1 = 7; ex_rs2 = 7; wb_rd = 7; wb_wen = 1;
    check("R3 wb to both", 9'b00000_01_01);
  endtask

  task automatic t_fwd_both();
    clear();
    ex_rs1 = 9; ex_rs2 = 3; mem_rd = 9; mem_wen = 1; wb_rd = 9; wb_wen = 1;
    check("R4 mem beats wb", 9'b00000_10_00);
    clear();
    ex_rs1 = 9; ex_rs2 = 3; mem_rd = 3; mem_wen = 1; wb_rd = 9; wb_wen = 1;
    check("R4 split sources", 9'b00000_01_10);
  endtask

  task automatic t_zero();
    clear();
    mem_rd = 0; mem_wen = 1; wb_rd = 0; wb_wen = 1;
    check("R5 x0 not forwarded", 9'b00000_00_00);
    clear();
    ex_is_load = 1; ex_wen = 1; ex_rd = 0;
    check("R5 load to x0 no stall", 9'b00000_00_00);
  endtask

  task automatic t_load_use();
    clear();
    ex_is_load = 1; ex_wen = 1; ex_rd = 14; id_rs1 = 14; id_rs2 = 2;
    check("R6 load-use on rs1", 9'b11100_00_00);
    clear();
    ex_is_load = 1; ex_wen = 1; ex_rd = 21; id_rs1 = 1; id_rs2 = 21;
    check("R6 load-use on rs2", 9'b11100_00_00);
  endtask

  task automatic t_no_stall();
    clear();
    ex_is_load = 0; ex_wen = 1; ex_rd = 14; id_rs1 = 14; id_rs2 = 14;
    check("R7 alu result no stall", 9'b00000_00_00);
  endtask

  task automatic t_branch();
    clear();
    ex_br_taken = 1;
    check("R8 taken branch", 9'b00011_00_00);
  endtask

  task automatic t_jump();
    clear();
    ex_jump = 1;
    check("R9 jump", 9'b00011_00_00);
  endtask

  task automatic t_flush_vs_stall();
    clear();
    ex_is_load = 1; ex_wen = 1; ex_rd = 6; id_rs1 = 6; ex_br_taken = 1;
    check("R10 branch over stall", 9'b00011_00_00);
    clear();
    ex_is_load = 1; ex_wen = 1; ex_rd = 6; id_rs2 = 6; ex_jump = 1;
    check("R10 jump over stall", 9'b00011_00_00);
  endtask

  task automatic t_not_taken();
    clear();
    ex_rs1 = 4; mem_rd = 4; mem_wen = 1;
    check("R11 not-taken branch no flush", 9'b00000_10_00);
  endtask

  initial begin
    t_idle();
    t_fwd_mem();
    t_fwd_wb();
    t_fwd_both();
    t_zero();
    t_load_use();
    t_no_stall();
    t_branch();
    t_jump();
    t_flush_vs_stall();
    t_not_taken();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule